// File: doc/BRIEF.md
# Byte-Bus Latched Address SRAM Bridge

This block lets a host with very few spare pins reach a byte-wide asynchronous SRAM with a 19-bit address. The host provides twelve lines: an 8-bit byte bus that it shares for address and data, a 3-bit select code, and one active-low gate. The block decodes the select code into one of five strobes. Each strobe is active only while the gate is low.

Three of the strobes load address registers: low byte, middle byte, and a high register that holds the top three address bits and an indicator output. The other two strobes drive the SRAM read and write enables directly. The host loads the address with one gate pulse for each register it needs to change. It then issues one gate pulse with the read or write code.

During a read pulse the SRAM's data reaches the host's return bus. The host samples it after a short settling delay. At every other time the SRAM data pins stay off the shared bus.

Top module: `latched_sram_bridge`

## Requirements
- R1: During and directly after a synchronous reset, the address and the indicator output are zero. With the gate high, every strobe output is inactive.
- R2: Select code 000 with the gate low drives `sram_oe_n` low and `host_rdata_oe` high in the same cycle, and `host_rdata` equals `sram_dq_in`.
- R3: Select code 001 with the gate low drives `sram_we_n` low and `sram_dq_oe` high in the same cycle, with `sram_dq_out` equal to `host_wdata`.
- R4: Select code 010 loads address bits 7..0. The value loaded is the byte that was on the bus in the last cycle of the gate-low window. It appears on `sram_addr` in the second cycle after the strobe ends.
- R5: Select code 011 loads address bits 15..8, with the same timing as R4.
- R6: Select code 100 loads address bits 18..16 from bus bits 2..0, and `led_out` from bus bit 3, with the same timing as R4.
- R7: Select codes 101, 110 and 111 assert no strobe and change neither the address nor the indicator output.
- R8: With the gate high, any select code and any bus value leave every strobe inactive and the registers unchanged.
- R9: At most one of the read and write enables is active in any cycle.
- R10: A register loads only when its strobe ends, either because the gate rises or because the code changes while the gate stays low. Holding the gate low with a changing bus does not change the address.
- R11: Outside a code-000 gate-low window, `host_rdata_oe` is low and `host_rdata` is zero. Outside a code-001 gate-low window, `sram_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_gate_n | input | 1 | Active-low gate from the host |
| host_sel | input | 3 | Strobe select code |
| host_wdata | input | 8 | Byte driven by the host onto the shared bus |
| host_rdata | output | 8 | SRAM byte returned to the host during a read window |
| host_rdata_oe | output | 1 | High while the return byte is driven |
| sram_addr | output | 19 | Registered SRAM address |
| sram_dq_out | output | 8 | Byte presented to the SRAM data pins |
| sram_dq_oe | output | 1 | High while the bridge drives the SRAM data pins |
| sram_dq_in | input | 8 | Byte read from the SRAM data pins |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_we_n | output | 1 | Active-low SRAM write enable |
| led_out | output | 1 | Indicator bit held in the high register |

## Verification
Two functions can fall in the same cycle: a register load that completes when one strobe ends, and the start of the next strobe. This happens when the host changes the select code without raising the gate.

The bench provokes this in two ways:
- It moves straight from a low-byte load to a write.
- It moves straight from a high-register load to a read.

In both cases the bench's behavioural model must show the new enable active at once, while the address still holds its old value for that cycle. The model must then show the newly loaded byte one cycle later. Both views are compared on every clock.

// File: rtl/latch_bridge_pkg.sv
package latch_bridge_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        CODE_READ  = 3'd0,
        CODE_WRITE = 3'd1,
        CODE_ALO   = 3'd2,
        CODE_AMID  = 3'd3,
        CODE_AHI   = 3'd4
    } sel_code_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ahi;
        logic amid;
        logic alo;
    } strobe_t;

    function automatic strobe_t decode_sel(input logic [SEL_W-1:0] sel, input logic gate_n);
        strobe_t s;
        s = '0;
        if (!gate_n) begin
            case (sel)
                CODE_READ:  s.rd   = 1'b1;
                CODE_WRITE: s.wr   = 1'b1;
                CODE_ALO:   s.alo  = 1'b1;
                CODE_AMID:  s.amid = 1'b1;
                CODE_AHI:   s.ahi  = 1'b1;
                default:    s      = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/bridge_sel_decoder.sv
module bridge_sel_decoder
    import latch_bridge_pkg::*;
(
    input  logic             gate_n,
    input  logic [SEL_W-1:0] sel,
    output strobe_t          strb
);
    always_comb begin
        strb = decode_sel(sel, gate_n);
    end
endmodule

// File: rtl/bridge_addr_reg.sv
module bridge_addr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic         strobe_q;
    logic [W-1:0] din_q;
    logic         release_evt;

    always_comb begin
        release_evt = strobe_q & ~strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            din_q    <= '0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            din_q    <= din;
            if (release_evt) begin
                q <= din_q;
            end
        end
    end
endmodule

// File: rtl/latched_sram_bridge.sv
module latched_sram_bridge
    import latch_bridge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_gate_n,
    input  logic [2:0]          host_sel,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rdata_oe,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [DATA_W-1:0]   sram_dq_out,
    output logic                sram_dq_oe,
    input  logic [DATA_W-1:0]   sram_dq_in,
    output logic                sram_oe_n,
    output logic                sram_we_n,
    output logic                led_out
);
    localparam int N_LANES = 2;
    localparam int HI_W    = ADDR_W - N_LANES * DATA_W;
    localparam int HREG_W  = HI_W + 1;

    strobe_t                  strb;
    logic [N_LANES-1:0]       lane_strb;
    logic [DATA_W-1:0]        lane_q [N_LANES];
    logic [HREG_W-1:0]        hreg_q;

    bridge_sel_decoder u_dec (
        .gate_n (host_gate_n),
        .sel    (host_sel),
        .strb   (strb)
    );

    assign lane_strb = {strb.amid, strb.alo};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        bridge_addr_reg #(.W(DATA_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .strobe (lane_strb[g]),
            .din    (host_wdata),
            .q      (lane_q[g])
        );
        assign sram_addr[g*DATA_W +: DATA_W] = lane_q[g];
    end

    bridge_addr_reg #(.W(HREG_W)) u_hreg (
        .clk    (clk),
        .rst    (rst),
        .strobe (strb.ahi),
        .din    (host_wdata[HREG_W-1:0]),
        .q      (hreg_q)
    );

    assign sram_addr[ADDR_W-1 -: HI_W] = hreg_q[HI_W-1:0];
    assign led_out                      = hreg_q[HI_W];

    always_comb begin
        sram_oe_n     = ~strb.rd;
        sram_we_n     = ~strb.wr;
        sram_dq_oe    = strb.wr;
        sram_dq_out   = host_wdata;
        host_rdata_oe = strb.rd;
        host_rdata    = strb.rd ? sram_dq_in : '0;
    end
endmodule

// File: rtl/latched_sram_bridge_chk.sv
module latched_sram_bridge_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              host_gate_n,
    input logic [2:0]        host_sel,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_rdata_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe,
    input logic [DATA_W-1:0] sram_dq_in,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              led_out
);
    logic no_load_strobe;
    assign no_load_strobe = host_gate_n || (host_sel < 3'd2) || (host_sel > 3'd4);

    assert_read_window_R2: assert property (@(posedge clk) disable iff (rst)
        (!host_gate_n && host_sel == 3'd0) |-> (!sram_oe_n && host_rdata_oe && host_rdata == sram_dq_in));

    assert_write_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!host_gate_n && host_sel == 3'd1) |-> (!sram_we_n && sram_dq_oe && sram_dq_out == host_wdata));

    assert_unused_codes_R7: assert property (@(posedge clk) disable iff (rst)
        (!host_gate_n && host_sel >= 3'd5) |-> (sram_oe_n && sram_we_n && !sram_dq_oe));

    assert_gate_high_idle_R8: assert property (@(posedge clk) disable iff (rst)
        host_gate_n |-> (sram_oe_n && sram_we_n && !sram_dq_oe && !host_rdata_oe));

    assert_one_enable_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~sram_oe_n, ~sram_we_n}));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (no_load_strobe && $past(no_load_strobe)) |=> ($stable(sram_addr) && $stable(led_out)));

    assert_bus_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        sram_oe_n |-> (!host_rdata_oe && host_rdata == '0));
endmodule

bind latched_sram_bridge latched_sram_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_gate_n   (host_gate_n),
    .host_sel      (host_sel),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_rdata_oe (host_rdata_oe),
    .sram_addr     (sram_addr),
    .sram_dq_out   (sram_dq_out),
    .sram_dq_oe    (sram_dq_oe),
    .sram_dq_in    (sram_dq_in),
    .sram_oe_n     (sram_oe_n),
    .sram_we_n     (sram_we_n),
    .led_out       (led_out)
);

// File: tb/latched_sram_bridge_bench.sv
module latched_sram_bridge_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_gate_n = 1'b1;
    logic [2:0]  host_sel = 3'd7;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        host_rdata_oe;
    logic [18:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic        sram_dq_oe;
    logic [7:0]  sram_dq_in = 8'h00;
    logic        sram_oe_n;
    logic        sram_we_n;
    logic        led_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string phase = "R1";

    // reference state
    logic [18:0] m_addr = '0;
    logic        m_led  = 1'b0;
    int          m_prev = -1;
    logic [7:0]  m_prev_data = 8'h00;

    latched_sram_bridge u_latched_sram_bridge (
        .clk(clk), .rst(rst), .host_gate_n(host_gate_n), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .led_out(led_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural model: a register loads from last window byte when its strobe ends
    always @(posedge clk) begin
        int cur;
        if (rst) begin
            m_addr = '0; m_led = 1'b0; m_prev = -1; m_prev_data = 8'h00;
        end else begin
            cur = host_gate_n ? -1 : int'(host_sel);
            if (m_prev >= 2 && m_prev <= 4 && cur != m_prev) begin
                if (m_prev == 2) m_addr[7:0]   = m_prev_data;
                if (m_prev == 3) m_addr[15:8]  = m_prev_data;
                if (m_prev == 4) begin
                    m_addr[18:16] = m_prev_data[2:0];
                    m_led         = m_prev_data[3];
                end
            end
            m_prev      = (cur >= 2 && cur <= 4) ? cur : -1;
            m_prev_data = host_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) t=%0t got=%h expected=%h", tag, phase, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit rd_win, wr_win;
            rd_win = !host_gate_n && host_sel == 3'd0;
            wr_win = !host_gate_n && host_sel == 3'd1;
            chk(rst ? "R1 addr" : "R4 addr_lo",  {24'd0, sram_addr[7:0]},  {24'd0, m_addr[7:0]});
            chk(rst ? "R1 addr" : "R5 addr_mid", {24'd0, sram_addr[15:8]}, {24'd0, m_addr[15:8]});
            chk(rst ? "R1 addr" : "R6 addr_hi",  {29'd0, sram_addr[18:16]}, {29'd0, m_addr[18:16]});
            chk(rst ? "R1 led" : "R6 led",       {31'd0, led_out}, {31'd0, m_led});
            chk("R2 oe_n",   {31'd0, sram_oe_n}, {31'd0, !rd_win});
            chk("R2 rd_oe",  {31'd0, host_rdata_oe}, {31'd0, rd_win});
            chk("R11 rdata", {24'd0, host_rdata}, rd_win ? {24'd0, sram_dq_in} : 32'd0);
            chk("R3 we_n",   {31'd0, sram_we_n}, {31'd0, !wr_win});
            chk("R3 dq_oe",  {31'd0, sram_dq_oe}, {31'd0, wr_win});
            chk("R3 dq_out", {24'd0, sram_dq_out}, {24'd0, host_wdata});
            chk("R9 enables", {30'd0, ~sram_oe_n, ~sram_we_n} == 32'd3 ? 32'd1 : 32'd0, 32'd0);
        end
    end

    task automatic drive(input logic g, input logic [2:0] s, input logic [7:0] d, input logic [7:0] q);
        @(posedge clk);
        #(CLK_P/4);
        host_gate_n = g; host_sel = s; host_wdata = d; sram_dq_in = q;
    endtask

    task automatic pulse(input logic [2:0] s, input logic [7:0] d, input int len);
        for (int i = 0; i < len; i++) drive(1'b0, s, d, 8'h3C ^ d);
        drive(1'b1, s, d, 8'h00);
        drive(1'b1, 3'd7, 8'hEE, 8'h00);
    endtask

    task automatic finish_run;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired, expected completion");
        finish_run();
    end

    initial begin
        phase = "R1";
        repeat (3) drive(1'b1, 3'd7, 8'h00, 8'h00);
        drive(1'b1, 3'd7, 8'h00, 8'h00);
        rst = 1'b0;
        drive(1'b1, 3'd7, 8'h00, 8'h00);

        phase = "R4"; pulse(3'd2, 8'h34, 2);
        phase = "R5"; pulse(3'd3, 8'h12, 1);
        phase = "R6"; pulse(3'd4, 8'h0D, 1);
        phase = "R6"; pulse(3'd4, 8'hF2, 3);
        phase = "R3"; pulse(3'd1, 8'hA5, 2);
        phase = "R2"; pulse(3'd0, 8'h00, 3);
        phase = "R7"; pulse(3'd5, 8'hFF, 2);
        pulse(3'd6, 8'hFF, 2);
        pulse(3'd7, 8'hFF, 2);

        phase = "R8";
        for (int c = 0; c < 8; c++) drive(1'b1, 3'(c), 8'(c * 37), 8'h5A);

        phase = "R10";
        drive(1'b0, 3'd2, 8'h11, 8'h00);
        drive(1'b0, 3'd2, 8'h22, 8'h00);
        drive(1'b0, 3'd2, 8'h77, 8'h00);
        drive(1'b0, 3'd1, 8'h99, 8'h00);
        drive(1'b0, 3'd1, 8'h98, 8'h00);
        drive(1'b1, 3'd1, 8'h98, 8'h00);
        drive(1'b0, 3'd4, 8'h0B, 8'h00);
        drive(1'b0, 3'd0, 8'h00, 8'hC3);
        drive(1'b0, 3'd0, 8'h00, 8'hC4);
        drive(1'b0, 3'd3, 8'hAB, 8'h00);
        drive(1'b0, 3'd2, 8'hCD, 8'h00);
        drive(1'b1, 3'd7, 8'h00, 8'h00);
        repeat (3) drive(1'b1, 3'd7, 8'h00, 8'h00);

        phase = "R1";
        rst = 1'b1;
        repeat (2) drive(1'b1, 3'd7, 8'h00, 8'h00);
        rst = 1'b0;
        repeat (2) drive(1'b1, 3'd7, 8'h00, 8'h00);
        finish_run();
    end
endmodule